// File: doc/BRIEF.md
# SAR Conversion Sequencer with Window Detect

This block is the digital half of a successive-approximation analog-to-digital converter. A 3-bit select field chooses which one of six sources may launch a conversion: a software start pulse, four synchronous hardware trigger pulses, or an asynchronous convert-start pin. Once a start is accepted, the sequencer holds a track phase and then resolves the result bit by bit, most significant first. For each bit it drives a candidate code to an external DAC, allows one settle cycle and samples an external comparator.

The finished code is latched into a result register and a sticky done flag is raised. The same code is checked against a greater-than and a less-than threshold. Each threshold arrives as a high field and a low byte. The relative order of the two thresholds decides whether the detector looks for results inside or outside the range, and a hit sets a sticky window flag. With the enable low the block stays in shutdown and ignores every start source.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, busy, done and the window flag are 0, and the result and the DAC code are all zeros.
- R2: Select code 0 starts on the software pulse, 1 on trigger A, 2 on trigger B, 3 on trigger C, 4 on a convert-pin rising edge and 5 on trigger D. A source that is not selected never starts a conversion.
- R3: Select codes 6 and 7 never start a conversion.
- R4: With the enable low, no start is accepted. Dropping the enable during a conversion clears busy on the next cycle, returns the DAC code to 0 and leaves done unchanged.
- R5: Busy goes high in the cycle after an accepted start and stays high for exactly TRACK_CYC + 2*RES_W cycles. The result and done update at the edge where busy falls.
- R6: During the track cycles the DAC code is 0. Each bit then shows its trial code (bits already resolved, plus the current bit set) for two cycles, MSB first. The comparator is sampled in the second cycle, where 1 keeps the bit and 0 clears it. Against an ideal comparator (input >= trial code) the result equals the input value.
- R7: Any start that arrives while busy is high is ignored and does not lengthen the conversion.
- R8: Done is set by each finished conversion and stays set until done_clr_i. When a set and a clear fall in the same cycle, the set wins.
- R9: When the greater-than threshold is less than or equal to the less-than threshold, a finished result r sets the window flag when gt <= r <= lt.
- R10: When the greater-than threshold exceeds the less-than threshold, a finished result sets the window flag when r <= lt or r >= gt.
- R11: The window flag stays set until win_clr_i, and a set in the same cycle wins over the clear. A later result that misses the window does not clear it.
- R12: The convert pin passes through a two-flop synchroniser and starts a conversion only on its rising edge. A pin held high starts exactly one conversion.
- R13: Each threshold value is {high field, low byte}. The high field holds bits RES_W-1..8 and the low byte holds bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable; 0 means shutdown |
| src_sel_i | input | 3 | Start-source select |
| sw_start_i | input | 1 | Software start pulse |
| trig_a_i | input | 1 | Hardware trigger A pulse |
| trig_b_i | input | 1 | Hardware trigger B pulse |
| trig_c_i | input | 1 | Hardware trigger C pulse |
| cnv_pin_i | input | 1 | Asynchronous convert-start pin |
| trig_d_i | input | 1 | Hardware trigger D pulse |
| cmp_i | input | 1 | Comparator output, 1 when input >= DAC code |
| gt_hi_i | input | RES_W-8 | Greater-than threshold, high field |
| gt_lo_i | input | 8 | Greater-than threshold, low byte |
| lt_hi_i | input | RES_W-8 | Less-than threshold, high field |
| lt_lo_i | input | 8 | Less-than threshold, low byte |
| done_clr_i | input | 1 | Clears the done flag |
| win_clr_i | input | 1 | Clears the window flag |
| dac_code_o | output | RES_W | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Sticky conversion-complete flag |
| result_o | output | RES_W | Last finished result |
| win_flag_o | output | 1 | Sticky window-detect flag |

## Verification
A wrong bit index or a slip in the keep/clear decision shows on the DAC code within two cycles of that bit's turn, and as a wrong result when busy falls. A miscounted track or step timer shows as a busy length other than TRACK_CYC + 2*RES_W. A wrong start decode shows within a few cycles as busy rising on an unselected or reserved source, or as busy staying low on the selected one. A wrong window mode or a wrong threshold split shows as a flag value that differs from the arithmetic expectation right after the result is latched.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_TRACK  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_DECIDE = 2'd3
   } sar_state_e;

   typedef enum logic [2:0] {
      SRC_SOFT   = 3'd0,
      SRC_TRIG_A = 3'd1,
      SRC_TRIG_B = 3'd2,
      SRC_TRIG_C = 3'd3,
      SRC_PIN    = 3'd4,
      SRC_TRIG_D = 3'd5,
      SRC_RSV6   = 3'd6,
      SRC_RSV7   = 3'd7
   } sar_src_e;

endpackage

// File: rtl/sar_start_sel.sv
module sar_start_sel
   import sar_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] src_sel_i,
   input  logic       sw_start_i,
   input  logic       trig_a_i,
   input  logic       trig_b_i,
   input  logic       trig_c_i,
   input  logic       cnv_pin_i,
   input  logic       trig_d_i,
   output logic       start_req_o
);

   localparam int LAST = SYNC_STAGES - 1;

   // synchroniser chain, one flop per generated stage
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      logic d;
      logic q;
      if (g == 0) begin : g_first
         assign d = cnv_pin_i;
      end else begin : g_next
         assign d = g_stage[g-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= d;
      end
   end

   logic pin_sync;
   logic pin_prev_q;
   logic pin_rise;

   assign pin_sync = g_stage[LAST].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev_q <= 1'b0;
      else        pin_prev_q <= pin_sync;
   end

   assign pin_rise = pin_sync & ~pin_prev_q;

   sar_src_e sel;
   assign sel = sar_src_e'(src_sel_i);

   always_comb begin
      unique case (sel)
         SRC_SOFT:   start_req_o = sw_start_i;
         SRC_TRIG_A: start_req_o = trig_a_i;
         SRC_TRIG_B: start_req_o = trig_b_i;
         SRC_TRIG_C: start_req_o = trig_c_i;
         SRC_PIN:    start_req_o = pin_rise;
         SRC_TRIG_D: start_req_o = trig_d_i;
         default:    start_req_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/sar_search.sv
module sar_search
   import sar_pkg::*;
#(
   parameter int RES_W     = 10,
   parameter int TRACK_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic             busy_o,
   output logic [RES_W-1:0] dac_code_o,
   output logic             fin_o,
   output logic [RES_W-1:0] fin_code_o
);

   localparam int TRK_W = (TRACK_CYC > 1) ? $clog2(TRACK_CYC) : 1;
   localparam int BIT_W = $clog2(RES_W);
   localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_W - 1);
   localparam logic [TRK_W-1:0] TRK_LOAD = TRK_W'(TRACK_CYC - 1);
   localparam logic [RES_W-1:0] ONE      = RES_W'(1);

   sar_state_e       state_q;
   logic [TRK_W-1:0] trk_q;
   logic [BIT_W-1:0] bit_q;
   logic [RES_W-1:0] code_q;

   logic [RES_W-1:0] bit_mask;
   logic [RES_W-1:0] kept;

   always_comb begin
      bit_mask   = ONE << bit_q;
      kept       = cmp_i ? code_q : (code_q & ~bit_mask);
      fin_o      = en_i && (state_q == ST_DECIDE) && (bit_q == '0);
      fin_code_o = kept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         trk_q   <= '0;
         bit_q   <= '0;
         code_q  <= '0;
      end else if (!en_i) begin
         state_q <= ST_IDLE;
         trk_q   <= '0;
         bit_q   <= '0;
         code_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_TRACK;
                  trk_q   <= TRK_LOAD;
                  code_q  <= '0;
               end
            end
            ST_TRACK: begin
               if (trk_q == '0) begin
                  state_q <= ST_SETTLE;
                  bit_q   <= TOP_BIT;
                  code_q  <= ONE << TOP_BIT;
               end else begin
                  trk_q <= trk_q - 1'b1;
               end
            end
            ST_SETTLE: state_q <= ST_DECIDE;
            ST_DECIDE: begin
               if (bit_q == '0) begin
                  state_q <= ST_IDLE;
                  code_q  <= '0;
               end else begin
                  state_q <= ST_SETTLE;
                  code_q  <= kept | (bit_mask >> 1);
                  bit_q   <= bit_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign dac_code_o = code_q;

endmodule

// File: rtl/sar_window.sv
module sar_window #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin_i,
   input  logic [RES_W-1:0] code_i,
   input  logic [RES_W-1:0] gt_thr_i,
   input  logic [RES_W-1:0] lt_thr_i,
   input  logic             clr_i,
   output logic             flag_o
);

   logic inside_mode;
   logic above_gt;
   logic below_lt;
   logic hit;

   always_comb begin
      inside_mode = (gt_thr_i <= lt_thr_i);
      above_gt    = (code_i >= gt_thr_i);
      below_lt    = (code_i <= lt_thr_i);
      hit         = inside_mode ? (above_gt && below_lt) : (above_gt || below_lt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag_o <= 1'b0;
      else if (fin_i && hit)  flag_o <= 1'b1;
      else if (clr_i)         flag_o <= 1'b0;
   end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
   import sar_pkg::*;
#(
   parameter int RES_W       = 10,
   parameter int TRACK_CYC   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic [2:0]         src_sel_i,
   input  logic               sw_start_i,
   input  logic               trig_a_i,
   input  logic               trig_b_i,
   input  logic               trig_c_i,
   input  logic               cnv_pin_i,
   input  logic               trig_d_i,
   input  logic               cmp_i,
   input  logic [RES_W-9:0]   gt_hi_i,
   input  logic [7:0]         gt_lo_i,
   input  logic [RES_W-9:0]   lt_hi_i,
   input  logic [7:0]         lt_lo_i,
   input  logic               done_clr_i,
   input  logic               win_clr_i,
   output logic [RES_W-1:0]   dac_code_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [RES_W-1:0]   result_o,
   output logic               win_flag_o
);

   if (RES_W < 9 || RES_W > 16) begin : g_bad_res
      $error("sar_seq_top: RES_W must lie in 9..16");
   end
   if (TRACK_CYC < 1) begin : g_bad_track
      $error("sar_seq_top: TRACK_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sar_seq_top: SYNC_STAGES must be at least 2");
   end

   logic             start_req;
   logic             fin;
   logic [RES_W-1:0] fin_code;
   logic [RES_W-1:0] gt_thr;
   logic [RES_W-1:0] lt_thr;

   assign gt_thr = {gt_hi_i, gt_lo_i};
   assign lt_thr = {lt_hi_i, lt_lo_i};

   sar_start_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_sel_i   (src_sel_i),
      .sw_start_i  (sw_start_i),
      .trig_a_i    (trig_a_i),
      .trig_b_i    (trig_b_i),
      .trig_c_i    (trig_c_i),
      .cnv_pin_i   (cnv_pin_i),
      .trig_d_i    (trig_d_i),
      .start_req_o (start_req)
   );

   sar_search #(.RES_W(RES_W), .TRACK_CYC(TRACK_CYC)) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .start_i    (start_req),
      .cmp_i      (cmp_i),
      .busy_o     (busy_o),
      .dac_code_o (dac_code_o),
      .fin_o      (fin),
      .fin_code_o (fin_code)
   );

   sar_window #(.RES_W(RES_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .fin_i    (fin),
      .code_i   (fin_code),
      .gt_thr_i (gt_thr),
      .lt_thr_i (lt_thr),
      .clr_i    (win_clr_i),
      .flag_o   (win_flag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         if (fin) result_o <= fin_code;
         if (fin)             done_o <= 1'b1;
         else if (done_clr_i) done_o <= 1'b0;
      end
   end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_W     = 10,
   parameter int TRACK_CYC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic [2:0]       src_sel_i,
   input logic             done_clr_i,
   input logic             win_clr_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             win_flag_o,
   input logic [RES_W-1:0] result_o,
   input logic [RES_W-1:0] dac_code_o
);

   localparam int CONV_CYC = TRACK_CYC + 2 * RES_W;
   localparam int CNT_W    = $clog2(CONV_CYC + 2);

   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   p_shutdown_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !busy_o);

   p_reserved_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && src_sel_i[2:1] == 2'b11) |=> !busy_o);

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && $past(en_i)) |-> (busy_cnt == CNT_W'(CONV_CYC)));

   p_busy_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CNT_W'(CONV_CYC));

   p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && $past(en_i)) |-> done_o);

   p_result_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> $stable(result_o));

   p_dac_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (dac_code_o == '0));

   p_track_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (dac_code_o == '0));

   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !done_clr_i) |=> done_o);

   p_win_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (win_flag_o && !win_clr_i) |=> win_flag_o);

endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W), .TRACK_CYC(TRACK_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_i       (en_i),
   .src_sel_i  (src_sel_i),
   .done_clr_i (done_clr_i),
   .win_clr_i  (win_clr_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .win_flag_o (win_flag_o),
   .result_o   (result_o),
   .dac_code_o (dac_code_o)
);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;

   localparam int RES_W     = 10;
   localparam int TRACK_CYC = 4;
   localparam int CONV_CYC  = TRACK_CYC + 2 * RES_W;
   localparam int MAXV      = (1 << RES_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [2:0] sel = 3'd0;
   logic sw = 0, ta = 0, tb = 0, tc = 0, pin = 0, td = 0;
   logic done_clr = 0, win_clr = 0;
   logic [RES_W-1:0] gt = '0, lt = '0;
   int   vin = 0;
   logic cmp;
   logic [RES_W-1:0] dac, result;
   logic busy, done, wflag;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   // ideal comparator: 1 when the input is at or above the trial code
   assign cmp = (vin >= int'(dac));

   sar_seq_top #(.RES_W(RES_W), .TRACK_CYC(TRACK_CYC), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .src_sel_i(sel),
      .sw_start_i(sw), .trig_a_i(ta), .trig_b_i(tb), .trig_c_i(tc),
      .cnv_pin_i(pin), .trig_d_i(td), .cmp_i(cmp),
      .gt_hi_i(gt[RES_W-1:8]), .gt_lo_i(gt[7:0]),
      .lt_hi_i(lt[RES_W-1:8]), .lt_lo_i(lt[7:0]),
      .done_clr_i(done_clr), .win_clr_i(win_clr),
      .dac_code_o(dac), .busy_o(busy), .done_o(done),
      .result_o(result), .win_flag_o(wflag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int win_exp(input int r, input int g, input int l);
      if (g <= l) return (r >= g && r <= l) ? 1 : 0;
      return (r <= l || r >= g) ? 1 : 0;
   endfunction

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      case (k)
         0: sw = 1; 1: ta = 1; 2: tb = 1; 3: tc = 1; 4: pin = 1; default: td = 1;
      endcase
      @(negedge clk);
      {sw, ta, tb, tc, pin, td} = '0;
   endtask

   task automatic conv_sw(input int v, output int n);
      vin = v;
      sel = 3'd0;
      pulse(0);
      wait_idle(n);
   endtask

   task automatic clear_flags();
      @(negedge clk);
      done_clr = 1; win_clr = 1;
      @(negedge clk);
      done_clr = 0; win_clr = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      int seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 win", wflag, 0);
      chk("R1 result", result, 0);
      chk("R1 dac", dac, 0);
      rst_n = 1;
      @(negedge clk);

      // R4 shutdown ignores a start
      vin = 100;
      pulse(0);
      repeat (3) @(negedge clk);
      chk("R4 no start when disabled", busy, 0);
      en = 1;
      @(negedge clk);

      // R5 busy length, R6 MSB-first trial codes
      vin = 682;
      pulse(0);
      chk("R5 busy after start", busy, 1);
      chk("R6 track dac", dac, 0);
      repeat (4) @(negedge clk);
      chk("R6 bit9 trial", dac, 512);
      repeat (2) @(negedge clk);
      chk("R6 bit8 trial", dac, 768);
      repeat (2) @(negedge clk);
      chk("R6 bit7 trial", dac, 640);
      wait_idle(n);
      chk("R5 busy cycles", n + 8, CONV_CYC);
      chk("R5 result", result, 682);
      chk("R5 done", done, 1);

      // R8 done sticky then clear
      repeat (10) @(negedge clk);
      chk("R8 done sticky", done, 1);
      clear_flags();
      chk("R8 done cleared", done, 0);

      // R8 set wins over a concurrent clear
      done_clr = 1;
      conv_sw(300, n);
      chk("R8 set wins", done, 1);
      done_clr = 0;
      clear_flags();

      // R6 sweep of every input value
      for (int v = 0; v <= MAXV; v++) begin
         conv_sw(v, n);
         if (result != v[RES_W-1:0])
            chk("R6 sweep result", result, v);
      end
      chk("R6 sweep end", result, MAXV);

      // R7 start during conversion ignored
      clear_flags();
      vin = 55;
      pulse(0);
      repeat (5) @(negedge clk);
      pulse(0);
      n = 0;
      wait_idle(n);
      chk("R7 busy length unchanged", n + 7, CONV_CYC);
      repeat (6) @(negedge clk);
      chk("R7 no restart", busy, 0);

      // R4 abort mid-conversion
      clear_flags();
      vin = 900;
      pulse(0);
      repeat (8) @(negedge clk);
      en = 0;
      @(negedge clk);
      chk("R4 abort busy", busy, 0);
      chk("R4 abort dac", dac, 0);
      chk("R4 abort no done", done, 0);
      en = 1;

      // R2 R3 R12 source map: every select against every source
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 6; k++) begin
            sel = 3'(s);
            vin = 77;
            pulse(k);
            seen = 0;
            for (int c = 0; c < 6; c++) begin
               if (busy) seen = 1;
               @(negedge clk);
            end
            if (busy) seen = 1;
            wait_idle(n);
            if (s >= 6) chk("R3 reserved select", seen, 0);
            else        chk("R2 source map", seen, (s == k) ? 1 : 0);
         end
      end

      // R12 pin held high starts only one conversion
      clear_flags();
      sel = 3'd4;
      vin = 400;
      @(negedge clk);
      pin = 1;
      seen = 0;
      for (int c = 0; c < 8; c++) begin
         if (busy) seen++;
         @(negedge clk);
      end
      wait_idle(n);
      chk("R12 pin start", seen > 0 ? 1 : 0, 1);
      seen = 0;
      for (int c = 0; c < 40; c++) begin
         if (busy) seen++;
         @(negedge clk);
      end
      chk("R12 held pin no second start", seen, 0);
      pin = 0;
      sel = 3'd0;

      // R9 R10 R13 window sweeps (thresholds span both fields)
      for (int m = 0; m < 3; m++) begin
         int g, l;
         g = (m == 0) ? 100 : (m == 1) ? 700 : 512;
         l = (m == 0) ? 300 : (m == 1) ? 260 : 512;
         gt = RES_W'(g);
         lt = RES_W'(l);
         for (int v = 0; v <= MAXV; v += 7) begin
            clear_flags();
            conv_sw(v, n);
            if (g <= l) chk("R9 inside window", wflag, win_exp(v, g, l));
            else        chk("R10 outside window", wflag, win_exp(v, g, l));
         end
      end
      // R13 value that only the high field separates
      gt = 10'd256; lt = 10'd511;
      clear_flags();
      conv_sw(255, n);
      chk("R13 split low miss", wflag, 0);
      clear_flags();
      conv_sw(256, n);
      chk("R13 split high hit", wflag, 1);

      // R11 sticky flag, later miss keeps it, clear, set wins
      conv_sw(10, n);
      chk("R11 miss keeps flag", wflag, 1);
      clear_flags();
      chk("R11 cleared", wflag, 0);
      win_clr = 1;
      conv_sw(300, n);
      chk("R11 set wins", wflag, 1);
      win_clr = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule